// File: doc/BRIEF.md
# Per-Line Hardware/Software Pad Steering Port

This block is an eight-line general-purpose I/O port. Each line can be set on its own to one of two owners. A software-owned line takes its drive value and its direction from registers that are reachable over an APB slave. A hardware-owned line passes an external auxiliary controller's drive value and active-low enable straight through to the pad. Pads are modelled as three separate signals: a drive value, an active-low drive enable and a sensed input.

The sensed pad value always returns to the software read path, so software can read back every line, whichever side owns it. On hardware-owned lines the sensed value also goes to the auxiliary controller. On software-owned lines the controller's copy is held at zero, so that it does not toggle needlessly. Software reads of pad values pass through a two-stage synchronizer. The controller's copy is taken directly from the pad with no register in between.

Top module: `gpio_mode_mux`

## Requirements
- R1: While the block is in reset, and after it leaves reset, the mode, direction and data registers are all 0. As a result, every pad enable is 1 (input), every pad drive value is 0, and every hardware-side sensed output is 0.
- R2: On a line whose mode bit is 1, the pad enable equals that line's active-low hardware enable input, and the pad drive value equals that line's hardware drive input.
- R3: On a line whose mode bit is 1, changing the direction or data register bit has no effect on the pad enable or the pad drive value.
- R4: On a line whose mode bit is 0, the pad enable is the inverse of the direction bit (direction 1 means output), and the pad drive value is the data register bit.
- R5: The hardware-side sensed output of a line equals the raw pad input, with no register in between, when the mode bit is 1. It is 0 when the mode bit is 0.
- R6: A read of the data register returns the pad inputs of all lines in bits [7:0], whatever the mode or direction of each line. The value comes from a two-flop synchronizer, so a change on a pad shows up on the read path after the second rising clock edge.
- R7: Reads of the direction and mode registers return the stored value. A write to the data register changes the stored drive bits but not what a data read returns.
- R8: The register map is at byte offsets 0x000 (data), 0x400 (direction) and 0x420 (mode select). Bits [31:8] of every read are 0. Any other offset, including a non-word-aligned one, reads 0, and a write to it changes no register.
- R9: A register is written only in the APB access phase (psel, penable and pwrite all 1). A setup phase by itself changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| hw_oe_n_i | input | 8 | Auxiliary controller active-low drive enable, per line |
| hw_dout_i | input | 8 | Auxiliary controller drive value, per line |
| hw_din_o | output | 8 | Sensed pad value to auxiliary controller, zero on software lines |
| pad_out_o | output | 8 | Pad drive value |
| pad_oe_n_o | output | 8 | Pad active-low drive enable |
| pad_in_i | input | 8 | Sensed pad value |

## Verification
The bench sweeps all 256 mode patterns. For each pattern it chooses direction, data, hardware and pad values so that every line sees both polarities on each source, and it computes the expected pad and hardware-side outputs bit by bit. If a mux had its select swapped, or if software-line gating were missing on the hardware-side output, some line in the sweep would show the wrong source. With all lines in hardware mode, the bench rewrites the direction and data registers. A design that let these registers leak through would move a pad. The bench samples the synchronized read one edge early and then on time: a design with one synchronizer stage too few or too many reports a value at the wrong time. It also checks a setup phase with no access phase, an unmapped offset and a misaligned offset. A loose address decode or a write strobe taken from the setup phase would corrupt a register in these cases.

// File: rtl/gpio_mm_pkg.sv
package gpio_mm_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_DATA = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_MODE = 12'h420;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_mm_rst.sv
module gpio_mm_rst (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/gpio_mm_sync.sv
module gpio_mm_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  // R6
  sync_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q == $past(meta_q));
endmodule

// File: rtl/gpio_mm_regs.sv
module gpio_mm_regs
  import gpio_mm_pkg::*;
#(
  parameter int unsigned N  = LINES,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  input  logic [N-1:0]  pad_sync_i,
  output logic [N-1:0]  dat_q,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  mode_q,
  output logic [DW-1:0] prdata
);
  localparam int unsigned PAD_W = DW - N;

  reg_sel_e     sel;
  logic         wr_en;
  logic [N-1:0] dat_d, dir_d, mode_d;
  logic [N-1:0] rd_val;
  logic         unused_wdata;

  assign unused_wdata = ^pwdata[DW-1:N];

  always_comb begin
    if      (paddr == OFS_DATA) sel = SEL_DATA;
    else if (paddr == OFS_DIR)  sel = SEL_DIR;
    else if (paddr == OFS_MODE) sel = SEL_MODE;
    else                        sel = SEL_NONE;
  end

  assign wr_en = psel && penable && pwrite;

  always_comb begin
    dat_d  = dat_q;
    dir_d  = dir_q;
    mode_d = mode_q;
    if (wr_en) begin
      unique case (sel)
        SEL_DATA: dat_d  = pwdata[N-1:0];
        SEL_DIR:  dir_d  = pwdata[N-1:0];
        SEL_MODE: mode_d = pwdata[N-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      dir_q  <= '0;
      mode_q <= '0;
    end else begin
      dat_q  <= dat_d;
      dir_q  <= dir_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    rd_val = '0;
    if (psel && !pwrite) begin
      unique case (sel)
        SEL_DATA: rd_val = pad_sync_i;
        SEL_DIR:  rd_val = dir_q;
        SEL_MODE: rd_val = mode_q;
        default:  rd_val = '0;
      endcase
    end
  end

  assign prdata = {{PAD_W{1'b0}}, rd_val};

  // R9
  setup_only_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |=> $stable(dat_q) && $stable(dir_q) && $stable(mode_q));

  // R8
  unmapped_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && sel == SEL_NONE)
      |=> $stable(dat_q) && $stable(dir_q) && $stable(mode_q));
endmodule

// File: rtl/gpio_mm_line.sv
module gpio_mm_line (
  input  logic mode_i,
  input  logic dir_i,
  input  logic dat_i,
  input  logic hw_oe_n_i,
  input  logic hw_dout_i,
  input  logic pad_in_i,
  output logic pad_out_o,
  output logic pad_oe_n_o,
  output logic hw_din_o
);
  always_comb begin
    if (mode_i) begin
      pad_out_o  = hw_dout_i;
      pad_oe_n_o = hw_oe_n_i;
    end else begin
      pad_out_o  = dat_i;
      pad_oe_n_o = ~dir_i;
    end
    hw_din_o = mode_i & pad_in_i;
  end
endmodule

// File: rtl/gpio_mode_mux.sv
module gpio_mode_mux
  import gpio_mm_pkg::*;
#(
  parameter int unsigned N  = LINES,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic [N-1:0]  hw_oe_n_i,
  input  logic [N-1:0]  hw_dout_i,
  output logic [N-1:0]  hw_din_o,
  output logic [N-1:0]  pad_out_o,
  output logic [N-1:0]  pad_oe_n_o,
  input  logic [N-1:0]  pad_in_i
);
  logic         rst_n;
  logic [N-1:0] pad_sync;
  logic [N-1:0] dat_q, dir_q, mode_q;

  gpio_mm_rst u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_n)
  );

  gpio_mm_sync #(.W(N)) u_sync (
    .clk   (pclk),
    .rst_n (rst_n),
    .d_i   (pad_in_i),
    .q_o   (pad_sync)
  );

  gpio_mm_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk        (pclk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .pad_sync_i (pad_sync),
    .dat_q      (dat_q),
    .dir_q      (dir_q),
    .mode_q     (mode_q),
    .prdata     (prdata)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    gpio_mm_line u_line (
      .mode_i     (mode_q[i]),
      .dir_i      (dir_q[i]),
      .dat_i      (dat_q[i]),
      .hw_oe_n_i  (hw_oe_n_i[i]),
      .hw_dout_i  (hw_dout_i[i]),
      .pad_in_i   (pad_in_i[i]),
      .pad_out_o  (pad_out_o[i]),
      .pad_oe_n_o (pad_oe_n_o[i]),
      .hw_din_o   (hw_din_o[i])
    );
  end

  // R1
  reset_all_inputs_chk: assert property (@(posedge pclk)
    !rst_n |-> (&pad_oe_n_o) && (pad_out_o == '0) && (hw_din_o == '0));

  // R3
  hw_lines_ignore_regs_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    ($stable(mode_q) && $stable(hw_oe_n_i) && $stable(hw_dout_i))
      |-> $stable(pad_oe_n_o & mode_q) && $stable(pad_out_o & mode_q));

  // R5
  sw_lines_quiet_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (hw_din_o & ~mode_q) == '0);
endmodule

// File: tb/gpio_mode_mux_tb.sv
module gpio_mode_mux_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [7:0]  hw_oe_n_i, hw_dout_i, hw_din_o, pad_out_o, pad_oe_n_o, pad_in_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  gpio_mode_mux u_dut (
    .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .hw_oe_n_i, .hw_dout_i, .hw_din_o, .pad_out_o, .pad_oe_n_o, .pad_in_i
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  d, dat, hoe, hdo, pin, exp_oe, exp_out, exp_din;
    logic [7:0]  save_oe, save_out;

    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    hw_oe_n_i = 8'h00; hw_dout_i = 8'hFF; pad_in_i = 8'hFF;
    repeat (5) @(posedge pclk);
    #1;
    // R1 during reset
    check("R1 oe_n in reset", {24'h0, pad_oe_n_o}, 32'hFF);
    check("R1 out in reset",  {24'h0, pad_out_o},  32'h00);
    check("R1 hw_din in reset", {24'h0, hw_din_o}, 32'h00);
    @(negedge pclk) presetn = 1'b1;
    repeat (4) @(negedge pclk);
    check("R1 oe_n after reset", {24'h0, pad_oe_n_o}, 32'hFF);
    check("R1 hw_din after reset", {24'h0, hw_din_o}, 32'h00);
    apb_read(12'h400, rd); check("R1 dir reset", rd, 32'h0);
    apb_read(12'h420, rd); check("R1 mode reset", rd, 32'h0);

    // Sweep all mode patterns: R2, R4, R5, R7, R3
    for (int m = 0; m < 256; m++) begin
      d   = 8'(m) ^ 8'h3C;
      dat = ~8'(m) ^ 8'h96;
      hoe = 8'(m * 37 + 11);
      hdo = 8'(m * 91 + 5);
      pin = 8'(m * 53 + 200);
      apb_write(12'h420, {24'hABCDEF, 8'(m)});
      apb_write(12'h400, {24'h123456, d});
      apb_write(12'h000, {24'h0, dat});
      @(negedge pclk);
      hw_oe_n_i = hoe; hw_dout_i = hdo; pad_in_i = pin;
      #1;
      exp_oe  = (8'(m) & hoe) | (~8'(m) & ~d);
      exp_out = (8'(m) & hdo) | (~8'(m) & dat);
      exp_din = 8'(m) & pin;
      check("R2 R4 pad enable mux", {24'h0, pad_oe_n_o}, {24'h0, exp_oe});
      check("R2 R4 pad value mux",  {24'h0, pad_out_o},  {24'h0, exp_out});
      check("R5 hw sensed gating",  {24'h0, hw_din_o},   {24'h0, exp_din});
      if (m % 17 == 0) begin
        apb_read(12'h420, rd); check("R7 mode readback", rd, {24'h0, 8'(m)});
        apb_read(12'h400, rd); check("R7 dir readback", rd, {24'h0, d});
        apb_read(12'h000, rd); check("R7 data read shows pads", rd, {24'h0, pin});
        save_oe  = pad_oe_n_o & 8'(m);
        save_out = pad_out_o & 8'(m);
        apb_write(12'h400, {24'h0, ~d});
        apb_write(12'h000, {24'h0, ~dat});
        #1;
        check("R3 hw enable unaffected", {24'h0, pad_oe_n_o & 8'(m)}, {24'h0, save_oe});
        check("R3 hw value unaffected",  {24'h0, pad_out_o & 8'(m)},  {24'h0, save_out});
        check("R4 sw after rewrite", {24'h0, pad_out_o & ~8'(m)}, {24'h0, ~dat & ~8'(m)});
      end
    end

    // R6 synchronizer latency
    apb_write(12'h420, 32'h0000_00F0);
    @(negedge pclk);
    pad_in_i = 8'h00;
    repeat (3) @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 12'h000;
    pad_in_i = 8'h5A;
    #1 check("R5 raw hw sensed same cycle", {24'h0, hw_din_o}, 32'h50);
    @(negedge pclk);
    check("R6 one edge not yet", prdata, 32'h00);
    @(negedge pclk);
    check("R6 after two edges", prdata, 32'h5A);
    psel = 1'b0;

    // R8 unmapped and misaligned offsets
    apb_write(12'h420, 32'h0000_0000);
    apb_write(12'h400, 32'h0000_0011);
    apb_write(12'h404, 32'h0000_00FF);
    apb_write(12'h402, 32'h0000_00FF);
    apb_write(12'h422, 32'h0000_00FF);
    apb_read(12'h400, rd); check("R8 dir untouched by unmapped write", rd, 32'h11);
    apb_read(12'h420, rd); check("R8 mode untouched by unmapped write", rd, 32'h00);
    apb_read(12'h404, rd); check("R8 unmapped reads zero", rd, 32'h0);
    apb_read(12'h401, rd); check("R8 misaligned reads zero", rd, 32'h0);
    #1 check("R8 pads follow dir 0x11", {24'h0, pad_oe_n_o}, 32'hEE);

    // R9 setup phase only
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h400; pwdata = 32'hFF;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge pclk);
    apb_read(12'h400, rd); check("R9 setup-only write ignored", rd, 32'h11);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule